// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the byte-wide register file that software uses to drive an SMBus host controller. It holds a target address, a command byte, two data bytes and a 32-byte block buffer. When software writes the control register with the start bit set, the block decodes the protocol field and sends one transaction request to a downstream bus engine. The bus engine does the bit-level signalling. When the engine responds, the block stores any read result in the data registers, reports completion or error in the status register, and clears the busy flag.

The engine side uses two valid/ready channels:
- **Request channel.** `req_valid` rises one cycle after an accepted start. It stays high, with every `req_*` field held constant, until the engine raises `req_ready`. A request is taken in any cycle where both are high.
- **Response channel.** `resp_ready` is high only while the block waits for the reply to a request that has been taken. A response is consumed in the cycle where `resp_valid` and `resp_ready` are both high.

The engine reaches the block buffer through a side port. It has a combinational read address and a write strobe, so the engine can fetch bytes for a block write and deposit bytes for a block read.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads 0: status, control, command, address, data0, data1. The block index is 0, and `req_valid` and `resp_ready` are low.
- R2: Reads are combinational on `host_rdata` and decode these offsets: 0 status, 2 control, 3 command, 4 address, 5 data0, 6 data1, 7 block port. Offset 1 reads 0. Control reads return only its stored bits 4:0.
- R3: While idle, a control write with bit 6 set stores bits 4:0, sets status bit 0 (busy), and issues one request. The request carries: protocol = control bits 4:2, read flag = address bit 0, target = address bits 7:1, the command byte, and data = {data1, data0}. The request fields stay stable until the engine accepts the request.
- R4: While busy, a control write is ignored entirely. The stored control bits and the request are unchanged, and no second request is issued.
- R5: Protocol codes are 0 quick, 1 byte, 2 byte-data, 3 word, 5 block. An accepted response clears busy. It then sets status bit 1 (done) on success, or status bit 2 (error) when `resp_error` is high. A new start clears both bits.
- R6: A successful read stores results as follows: byte and byte-data put `resp_data[7:0]` into data0; word puts the low byte into data0 and the high byte into data1; block puts the returned count (`resp_data[7:0]`) into data0. Writes, quick commands and errored responses leave data0 and data1 unchanged.
- R7: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 has no effect. Status bit 0 is unaffected by writes.
- R8: Each read or write of offset 7 accesses the buffer at the current index and then increments the index. The index wraps from 31 to 0.
- R9: An accepted start resets the block index to 0. During a block write, the engine reads the bytes at indices 0 up to data0 minus 1 through the side port.
- R10: An accepted start with protocol code 4, 6 or 7 issues no request and sets status bit 2 in the next cycle. Busy stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (advances the block index at offset 7) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational |
| req_valid | output | 1 | Transaction request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_proto | output | 3 | Protocol code |
| req_read | output | 1 | 1 = read transaction |
| req_target | output | 7 | 7-bit target address |
| req_cmd | output | 8 | Command byte |
| req_data | output | 16 | {data1, data0}; data0 is the count for a block write |
| resp_valid | input | 1 | Engine response valid |
| resp_ready | output | 1 | Block waits for a response |
| resp_error | input | 1 | Device error on the transaction |
| resp_data | input | 16 | Read result, or block count in bits 7:0 |
| eng_buf_we | input | 1 | Engine buffer write strobe |
| eng_buf_waddr | input | 5 | Engine buffer write index |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_raddr | input | 5 | Engine buffer read index |
| eng_buf_rdata | output | 8 | Engine buffer read data, combinational |

## Verification
Each kind of internal fault shows up at the ports within a short, bounded time:
- **Latched request fields.** A wrong protocol or target latch is visible on the `req_*` fields in the first cycle of `req_valid`.
- **Controller state.** A stuck or skipped state shows as a missing `req_valid`, or as a busy bit that never clears once the response handshake completes.
- **Block index.** A wrong index is visible on the next block-port read. The wrap case is checked by wrapping the index past 31 and then reading back the byte stored at index 0.
- **Data capture.** A capture error shows up on data0 or data1 immediately after the response.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam logic [2:0] OFS_STS = 3'd0;
  localparam logic [2:0] OFS_CTL = 3'd2;
  localparam logic [2:0] OFS_CMD = 3'd3;
  localparam logic [2:0] OFS_ADR = 3'd4;
  localparam logic [2:0] OFS_DT0 = 3'd5;
  localparam logic [2:0] OFS_DT1 = 3'd6;
  localparam logic [2:0] OFS_BLK = 3'd7;

  localparam int CTL_GO_BIT = 6;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WORD  = 3'd3,
    PR_BLOCK = 3'd5
  } proto_e;

  function automatic logic proto_known(input logic [2:0] code);
    return (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BDATA) ||
           (code == PR_WORD) || (code == PR_BLOCK);
  endfunction
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_clr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic          eng_we,
  input  logic [IW-1:0] eng_waddr,
  input  logic [W-1:0]  eng_wdata,
  input  logic [IW-1:0] eng_raddr,
  output logic [W-1:0]  eng_rdata
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] idx;
  logic          step;

  assign step       = host_wr || host_rd;
  assign host_rdata = mem[idx];
  assign eng_rdata  = mem[eng_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_clr) begin
      idx <= '0;
    end else if (step) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (eng_we) mem[eng_waddr] <= eng_wdata;
      if (host_wr) mem[idx] <= host_wdata;
    end
  end

  // R8
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_clr && idx == LAST) |=> (idx == '0));
  // R9
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (idx == '0));
endmodule

// File: rtl/smb_txn_fsm.sv
module smb_txn_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_bad,
  input  logic req_ready,
  input  logic resp_valid,
  input  logic resp_error,
  output logic busy,
  output logic req_valid,
  output logic resp_ready,
  output logic fin_ok,
  output logic fin_err
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (launch && !launch_bad) st <= ST_REQ;
        ST_REQ:  if (req_ready) st <= ST_WAIT;
        ST_WAIT: if (resp_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic took;
  assign busy       = (st != ST_IDLE);
  assign req_valid  = (st == ST_REQ);
  assign resp_ready = (st == ST_WAIT);
  assign took       = resp_valid && resp_ready;
  assign fin_ok     = took && !resp_error;
  assign fin_err    = (took && resp_error) || (launch && launch_bad && st == ST_IDLE);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
  // R5
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_ready) |-> $past(req_valid && req_ready));
  // R4
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BUF_DEPTH = 32,
  localparam int IW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [2:0]    req_proto,
  output logic          req_read,
  output logic [DW-2:0] req_target,
  output logic [DW-1:0] req_cmd,
  output logic [2*DW-1:0] req_data,
  input  logic          resp_valid,
  output logic          resp_ready,
  input  logic          resp_error,
  input  logic [2*DW-1:0] resp_data,
  input  logic          eng_buf_we,
  input  logic [IW-1:0] eng_buf_waddr,
  input  logic [DW-1:0] eng_buf_wdata,
  input  logic [IW-1:0] eng_buf_raddr,
  output logic [DW-1:0] eng_buf_rdata
);
  logic [4:0]    ctl_q;
  logic [DW-1:0] cmd_q, adr_q, dt0_q, dt1_q;
  logic          st_done, st_err;
  logic          busy, fin_ok, fin_err, launch, launch_bad;
  logic [DW-1:0] blk_rdata;

  logic wr_sts, wr_ctl, wr_cmd, wr_adr, wr_dt0, wr_dt1, blk_wr, blk_rd;
  assign wr_sts = host_wr && host_addr == OFS_STS;
  assign wr_ctl = host_wr && host_addr == OFS_CTL;
  assign wr_cmd = host_wr && host_addr == OFS_CMD;
  assign wr_adr = host_wr && host_addr == OFS_ADR;
  assign wr_dt0 = host_wr && host_addr == OFS_DT0;
  assign wr_dt1 = host_wr && host_addr == OFS_DT1;
  assign blk_wr = host_wr && host_addr == OFS_BLK;
  assign blk_rd = host_rd && host_addr == OFS_BLK && !host_wr;

  assign launch     = wr_ctl && host_wdata[CTL_GO_BIT] && !busy;
  assign launch_bad = !proto_known(host_wdata[4:2]);

  smb_txn_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_bad(launch_bad),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_error(resp_error),
    .busy(busy), .req_valid(req_valid), .resp_ready(resp_ready),
    .fin_ok(fin_ok), .fin_err(fin_err)
  );

  smb_blk_buf #(.DEPTH(BUF_DEPTH), .W(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .idx_clr(launch),
    .host_wr(blk_wr), .host_rd(blk_rd), .host_wdata(host_wdata),
    .host_rdata(blk_rdata),
    .eng_we(eng_buf_we), .eng_waddr(eng_buf_waddr), .eng_wdata(eng_buf_wdata),
    .eng_raddr(eng_buf_raddr), .eng_rdata(eng_buf_rdata)
  );

  // register file and request latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; cmd_q <= '0; adr_q <= '0; dt0_q <= '0; dt1_q <= '0;
      st_done <= 1'b0; st_err <= 1'b0;
      req_proto <= '0; req_read <= 1'b0; req_target <= '0;
      req_cmd <= '0; req_data <= '0;
    end else begin
      if (wr_ctl && !busy) ctl_q <= host_wdata[4:0];
      if (wr_cmd) cmd_q <= host_wdata;
      if (wr_adr) adr_q <= host_wdata;
      if (wr_dt0) dt0_q <= host_wdata;
      if (wr_dt1) dt1_q <= host_wdata;

      if (wr_sts) begin
        if (host_wdata[1]) st_done <= 1'b0;
        if (host_wdata[2]) st_err  <= 1'b0;
      end
      if (launch) begin
        st_done    <= 1'b0;
        st_err     <= 1'b0;
        req_proto  <= host_wdata[4:2];
        req_read   <= adr_q[0];
        req_target <= adr_q[DW-1:1];
        req_cmd    <= cmd_q;
        req_data   <= {dt1_q, dt0_q};
      end
      if (fin_ok)  st_done <= 1'b1;
      if (fin_err) st_err  <= 1'b1;

      if (fin_ok && req_read) begin
        case (req_proto)
          PR_BYTE, PR_BDATA, PR_BLOCK: dt0_q <= resp_data[DW-1:0];
          PR_WORD: begin
            dt0_q <= resp_data[DW-1:0];
            dt1_q <= resp_data[2*DW-1:DW];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (host_addr)
      OFS_STS: host_rdata = {{(DW-3){1'b0}}, st_err, st_done, busy};
      OFS_CTL: host_rdata = {{(DW-5){1'b0}}, ctl_q};
      OFS_CMD: host_rdata = cmd_q;
      OFS_ADR: host_rdata = adr_q;
      OFS_DT0: host_rdata = dt0_q;
      OFS_DT1: host_rdata = dt1_q;
      OFS_BLK: host_rdata = blk_rdata;
      default: host_rdata = '0;
    endcase
  end

  // R3
  req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(req_proto) && $stable(req_target) &&
                                   $stable(req_cmd) && $stable(req_data) && $stable(req_read)));
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_done && st_err));
  // R10
  bad_proto_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && launch_bad) |=> (!req_valid && st_err));
  // R4
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl_q));
endmodule

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic req_valid, req_read, resp_ready;
  logic req_ready = 0, resp_valid = 0, resp_error = 0;
  logic [2:0] req_proto;
  logic [6:0] req_target;
  logic [7:0] req_cmd;
  logic [15:0] req_data, resp_data = 0;
  logic eng_buf_we = 0;
  logic [4:0] eng_buf_waddr = 0, eng_buf_raddr = 0;
  logic [7:0] eng_buf_wdata = 0, eng_buf_rdata;

  smb_host_regs u_dut (.*);

  int total = 0, bad = 0, nreq = 0;
  logic [2:0] c_proto; logic c_read; logic [6:0] c_tgt; logic [7:0] c_cmd; logic [15:0] c_data;

  always @(posedge clk) if (req_valid && req_ready) nreq <= nreq + 1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic serve(input logic [15:0] rdat, input logic err);
    @(negedge clk);
    while (!req_valid) @(negedge clk);
    c_proto = req_proto; c_read = req_read; c_tgt = req_target;
    c_cmd = req_cmd; c_data = req_data;
    req_ready = 1;
    @(negedge clk); req_ready = 0; resp_valid = 1; resp_data = rdat; resp_error = err;
    @(negedge clk); resp_valid = 0; resp_error = 0;
  endtask

  typedef struct packed {
    logic [2:0] pr; logic rdf; logic [15:0] rsp; logic er;
    logic [7:0] e0; logic [7:0] e1; logic [7:0] est;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{3'd0, 1'b0, 16'h0000, 1'b0, 8'h11, 8'h22, 8'h02},
    '{3'd1, 1'b1, 16'h005A, 1'b0, 8'h5A, 8'h22, 8'h02},
    '{3'd2, 1'b1, 16'h003C, 1'b0, 8'h3C, 8'h22, 8'h02},
    '{3'd3, 1'b1, 16'hBEEF, 1'b0, 8'hEF, 8'hBE, 8'h02},
    '{3'd3, 1'b0, 16'h9999, 1'b0, 8'h11, 8'h22, 8'h02},
    '{3'd1, 1'b1, 16'h0077, 1'b1, 8'h11, 8'h22, 8'h04},
    '{3'd5, 1'b1, 16'h0007, 1'b0, 8'h07, 8'h22, 8'h02}
  };

  initial begin : wdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk("R1 reset reg", {8'h0, v}, 16'h0);
    end
    chk("R1 req_valid", {15'h0, req_valid}, 16'h0);
    chk("R1 resp_ready", {15'h0, resp_ready}, 16'h0);

    // R9 block write: host fills 0..2 from index 0, engine reads side port
    wr(3'd7, 8'hC1); wr(3'd7, 8'hC2); wr(3'd7, 8'hC3);
    wr(3'd5, 8'h03); wr(3'd4, 8'hA0); wr(3'd2, 8'h40 | (8'd5 << 2));
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      eng_buf_raddr = 5'(k); #1 chk("R9 eng buf read", {8'h0, eng_buf_rdata}, 16'(8'hC1 + k));
    end
    serve(16'h0, 1'b0);
    chk("R9 count in req_data", c_data[7:0], 16'h03);

    // R9 start resets index
    wr(3'd7, 8'h55); wr(3'd7, 8'h66);
    wr(3'd2, 8'h40); serve(16'h0, 1'b0);
    rd(3'd7, v); chk("R9 idx reset on start", {8'h0, v}, 16'h55);

    // R8 wrap: new start gives index 0, then 33 writes
    wr(3'd2, 8'h40); serve(16'h0, 1'b0);
    for (int k = 0; k < 32; k++) wr(3'd7, 8'(k));
    wr(3'd7, 8'hAA);
    rd(3'd7, v); chk("R8 after wrap idx1", {8'h0, v}, 16'h01);
    for (int k = 2; k < 32; k++) rd(3'd7, v);
    rd(3'd7, v); chk("R8 wrapped byte idx0", {8'h0, v}, 16'hAA);

    // R7 W1C
    rd(3'd0, v); chk("R5 done set", {8'h0, v}, 16'h02);
    wr(3'd0, 8'h01); rd(3'd0, v); chk("R7 write 0 to done kept", {8'h0, v}, 16'h02);
    wr(3'd0, 8'h02); rd(3'd0, v); chk("R7 clear done", {8'h0, v}, 16'h00);

    // R2 decode
    wr(3'd2, 8'h9C); rd(3'd2, v); chk("R2 ctl low5", {8'h0, v}, 16'h1C);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 offset1 zero", {8'h0, v}, 16'h00);
    wr(3'd3, 8'h5E); rd(3'd3, v); chk("R2 cmd readback", {8'h0, v}, 16'h5E);

    // R3 R5 R6 vector walk
    for (int i = 0; i < 7; i++) begin
      wr(3'd3, 8'(8'h40 + i));
      wr(3'd4, {7'(8'h50 + i), VEC[i].rdf});
      wr(3'd5, 8'h11); wr(3'd6, 8'h22);
      n0 = nreq;
      wr(3'd2, 8'h40 | {3'b0, VEC[i].pr, 2'b0});
      rd(3'd0, v); chk("R3 busy", {8'h0, v}, 16'h01);
      if (VEC[i].pr == 3'd5 && VEC[i].rdf) begin
        for (int k = 0; k < 7; k++) begin
          @(negedge clk); eng_buf_we = 1; eng_buf_waddr = 5'(k); eng_buf_wdata = 8'(8'hA0 + k);
        end
        @(negedge clk); eng_buf_we = 0;
      end
      serve(VEC[i].rsp, VEC[i].er);
      chk("R3 proto", {13'h0, c_proto}, {13'h0, VEC[i].pr});
      chk("R3 read flag", {15'h0, c_read}, {15'h0, VEC[i].rdf});
      chk("R3 target", {9'h0, c_tgt}, 16'(7'(8'h50 + i)));
      chk("R3 cmd", {8'h0, c_cmd}, 16'(8'h40 + i));
      chk("R3 data", c_data, 16'h2211);
      chk("R3 one request", 16'(nreq - n0), 16'd1);
      rd(3'd5, v); chk("R6 data0", {8'h0, v}, {8'h0, VEC[i].e0});
      rd(3'd6, v); chk("R6 data1", {8'h0, v}, {8'h0, VEC[i].e1});
      rd(3'd0, v); chk("R5 status", {8'h0, v}, {8'h0, VEC[i].est});
      if (VEC[i].pr == 3'd5 && VEC[i].rdf) begin
        rd(3'd7, v); chk("R6 block byte0", {8'h0, v}, 16'hA0);
        rd(3'd7, v); chk("R6 block byte1", {8'h0, v}, 16'hA1);
      end
      wr(3'd0, 8'h06);
    end

    // R4 start while busy ignored
    wr(3'd4, 8'hA1);
    n0 = nreq;
    wr(3'd2, 8'h44);
    wr(3'd2, 8'h4C);
    rd(3'd2, v); chk("R4 ctl unchanged while busy", {8'h0, v}, 16'h04);
    serve(16'h0033, 1'b0);
    chk("R4 proto of first start", {13'h0, c_proto}, 16'h1);
    repeat (4) @(negedge clk);
    chk("R4 single request", 16'(nreq - n0), 16'd1);
    rd(3'd5, v); chk("R6 byte read after R4", {8'h0, v}, 16'h33);

    // R10 unsupported protocol
    n0 = nreq;
    wr(3'd2, 8'h40 | (8'd7 << 2));
    rd(3'd0, v); chk("R10 error no busy", {8'h0, v}, 16'h04);
    repeat (4) @(negedge clk);
    chk("R10 no request", 16'(nreq - n0), 16'd0);
    wr(3'd0, 8'h04); rd(3'd0, v); chk("R7 clear error", {8'h0, v}, 16'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule